// File: doc/BRIEF.md
# Byte-Register SPI Master

This block is a single-byte SPI master that software drives through seven byte-wide registers on a plain memory-mapped bus. The bus has an address, write data, read data and separate write and read strobes. A write to the data port starts one full-duplex exchange of eight bits. The byte goes out on MOSI, most significant bit first, while eight bits are taken in from MISO. Once the exchange ends, the captured byte can be read back from the same data port.

Software sets four things before an exchange: the enable bit, the clock polarity and phase, and a 4-bit divider code. The divider code selects the serial clock rate. Its two low bits sit in the control register and its two high bits sit in the extended control register. The code values are deliberately out of order, and each one picks a power-of-two ratio between 2 and 4096.

A status register reports three things: a completion flag, a write-collision flag and a receive-empty indicator. A separate select register drives four slave-select outputs. Each select has its own enable bit and its own level bit. A parameter byte and a timing byte are stored and read back, but neither one affects the exchanges.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the control register (offset 0x0) reads 0x00 and the status register (offset 0x1) reads 0x01. All select outputs are high and SCK is low.
- R2: These registers read back the whole byte last written to them: control (0x0), extended control (0x3), parameter (0x4), select (0x5) and timing (0x6). Status reads as {complete at bit 7, collision at bit 6, zeros in bits 5..1, receive-empty at bit 0}.
- R3: The divider code is {extended[1:0], control[1:0]}, and one SCK period lasts N clocks. The code-to-N mapping is: 0→2, 1→4, 4→8, 2→16, 3→32, 5→64, 6→128, 7→256, 8→512, 9→1024, 10→2048, 11→4096. Codes 12 to 15 give 4096.
- R4: A write to the data port (0x2) while control bit 6 is 1 and no exchange is running starts one exchange. The exchange shifts the byte out MSB first and captures 8 MISO bits. A read of 0x2 returns the captured byte.
- R5: Control bit 3 sets the SCK idle level. With control bit 2 at 0, MISO is sampled on leading edges and MOSI changes on trailing edges. With control bit 2 at 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R6: Status bit 7 becomes 1 when the exchange ends. Writing 1 to status bit 7 clears it, and writing 0 leaves it unchanged.
- R7: Status bit 0 is 1 from reset and from the start of each exchange. It becomes 0 when the exchange ends. A read of the data port sets it back to 1.
- R8: A data-port write during an exchange sets status bit 6. It changes neither the bits being shifted out nor the captured byte. Writing 1 to status bit 6 clears it.
- R9: While control bit 6 is 0, SCK stays at the level of control bit 3. A data-port write then starts nothing: status stays 0x01.
- R10: For each select n from 0 to 3, bit n of the select register enables software control and bit n+4 is the level driven on that output. A select whose enable bit is 0 is driven high.
- R11: The parameter register, including bit 0 at either value, never blocks or alters a data-port exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_n | output | 4 | Slave-select outputs |

## Verification
The bench builds the block with its default parameters: four selects, and a divider counter wide enough for the largest ratio of 4096. With these values every select bit pattern can be reached. The slowest divider codes can also be reached, including the codes above 11 that clamp to 4096, within a run of about a hundred thousand cycles. All four polarity and phase combinations are run at the fastest ratio against a slave model that follows the same edge rules. The collision case runs at a ratio of 32, which leaves time to write the data port in the middle of an exchange.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

  localparam logic [2:0] ADR_CTRL   = 3'h0;
  localparam logic [2:0] ADR_STAT   = 3'h1;
  localparam logic [2:0] ADR_DATA   = 3'h2;
  localparam logic [2:0] ADR_EXT    = 3'h3;
  localparam logic [2:0] ADR_PARAM  = 3'h4;
  localparam logic [2:0] ADR_SEL    = 3'h5;
  localparam logic [2:0] ADR_TIMING = 3'h6;

  localparam int DIV_EXP_MAX = 12;

  // Divider code to log2 of the clock ratio (ratio = 2**exp).
  function automatic logic [3:0] div_exp(input logic [3:0] code);
    logic [3:0] e;
    case (code)
      4'd0:    e = 4'd1;
      4'd1:    e = 4'd2;
      4'd4:    e = 4'd3;
      4'd2:    e = 4'd4;
      4'd3:    e = 4'd5;
      default: e = (code >= 4'd12) ? 4'd12 : code + 4'd1;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/spi_bm_clkdiv.sv
module spi_bm_clkdiv #(
  parameter int EXP_MAX = spi_bm_pkg::DIV_EXP_MAX
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] code,
  output logic       tick
);
  localparam int CNT_W = EXP_MAX - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic [CNT_W:0]   half;
  logic [3:0]       ex;

  always_comb begin
    ex      = spi_bm_pkg::div_exp(code);
    half    = (CNT_W+1)'(1) << (ex - 4'd1);
    half_m1 = CNT_W'(half - (CNT_W+1)'(1));
    tick    = run && (cnt_q == half_m1);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_bm_engine.sv
module spi_bm_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic              cpha,
  input  logic [DATA_W-1:0] tx_in,
  input  logic              miso,
  output logic              busy,
  output logic              sck_int,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done_pulse
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic              busy_q, busy_d;
  logic [EW-1:0]     edge_q, edge_d;
  logic              sck_q, sck_d;
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              leading, sample_now;

  always_comb begin
    busy_d     = busy_q;
    edge_d     = edge_q;
    sck_d      = sck_q;
    tx_d       = tx_q;
    rx_d       = rx_q;
    done_pulse = 1'b0;
    leading    = ~edge_q[0];
    sample_now = leading ^ cpha;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        edge_d = '0;
        sck_d  = 1'b0;
        tx_d   = tx_in;
      end
    end else if (tick) begin
      sck_d  = ~sck_q;
      edge_d = edge_q + EW'(1);
      if (sample_now)            rx_d = {rx_q[DATA_W-2:0], miso};
      else if (edge_q != '0)     tx_d = {tx_q[DATA_W-2:0], 1'b0};
      if (edge_q == LAST) begin
        busy_d     = 1'b0;
        done_pulse = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      sck_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      edge_q <= edge_d;
      sck_q  <= sck_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign sck_int = sck_q;
  assign mosi    = tx_q[DATA_W-1];
  assign rx_byte = rx_q;

  assert_sck_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(sck_q));

endmodule

// File: rtl/spi_bm_regs.sv
module spi_bm_regs #(
  parameter int NUM_SEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         addr,
  input  logic [7:0]         wdata,
  input  logic               we,
  input  logic               re,
  output logic [7:0]         rdata,
  input  logic               busy,
  input  logic               done_pulse,
  input  logic [7:0]         rx_byte,
  output logic               en,
  output logic               cpol,
  output logic               cpha,
  output logic [3:0]         div_code,
  output logic               start,
  output logic [7:0]         tx_byte,
  output logic [NUM_SEL-1:0] sel_n
);
  import spi_bm_pkg::*;

  logic [7:0] ctrl_q, ctrl_d, ext_q, ext_d, param_q, param_d;
  logic [7:0] sel_q, sel_d, tim_q, tim_d;
  logic       done_q, done_d, wcol_q, wcol_d, rxe_q, rxe_d;
  logic       hit_data, hit_stat;

  always_comb begin
    hit_data = we && (addr == ADR_DATA);
    hit_stat = we && (addr == ADR_STAT);
    start    = hit_data && ctrl_q[6] && !busy;
    tx_byte  = wdata;

    ctrl_d  = ctrl_q;
    ext_d   = ext_q;
    param_d = param_q;
    sel_d   = sel_q;
    tim_d   = tim_q;
    if (we) begin
      case (addr)
        ADR_CTRL:   ctrl_d  = wdata;
        ADR_EXT:    ext_d   = wdata;
        ADR_PARAM:  param_d = wdata;
        ADR_SEL:    sel_d   = wdata;
        ADR_TIMING: tim_d   = wdata;
        default: ;
      endcase
    end

    done_d = done_q;
    if (done_pulse)                done_d = 1'b1;
    else if (hit_stat && wdata[7]) done_d = 1'b0;

    wcol_d = wcol_q;
    if (hit_data && busy)          wcol_d = 1'b1;
    else if (hit_stat && wdata[6]) wcol_d = 1'b0;

    rxe_d = rxe_q;
    if (done_pulse)                         rxe_d = 1'b0;
    else if (start)                         rxe_d = 1'b1;
    else if (re && (addr == ADR_DATA))      rxe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ext_q   <= '0;
      param_q <= '0;
      sel_q   <= '0;
      tim_q   <= '0;
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
      rxe_q   <= 1'b1;
    end else begin
      ctrl_q  <= ctrl_d;
      ext_q   <= ext_d;
      param_q <= param_d;
      sel_q   <= sel_d;
      tim_q   <= tim_d;
      done_q  <= done_d;
      wcol_q  <= wcol_d;
      rxe_q   <= rxe_d;
    end
  end

  always_comb begin
    case (addr)
      ADR_CTRL:   rdata = ctrl_q;
      ADR_STAT:   rdata = {done_q, wcol_q, 5'b0, rxe_q};
      ADR_DATA:   rdata = rx_byte;
      ADR_EXT:    rdata = ext_q;
      ADR_PARAM:  rdata = param_q;
      ADR_SEL:    rdata = sel_q;
      ADR_TIMING: rdata = tim_q;
      default:    rdata = '0;
    endcase
  end

  assign en       = ctrl_q[6];
  assign cpol     = ctrl_q[3];
  assign cpha     = ctrl_q[2];
  assign div_code = {ext_q[1:0], ctrl_q[1:0]};

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign sel_n[i] = sel_q[i] ? sel_q[i+4] : 1'b1;

    assert_sel_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q[i] |-> sel_n[i]);
  end

  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (done_q && !rxe_q));

  assert_rd_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (re && (addr == ADR_DATA) && !done_pulse) |=> rxe_q);

  assert_wcol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && busy) |=> wcol_q);

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int NUM_SEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_we,
  input  logic               bus_re,
  output logic [7:0]         bus_rdata,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_SEL-1:0] sel_n
);
  localparam int DATA_W = 8;

  logic              en, cpol, cpha, start, busy, tick, sck_int, done_pulse;
  logic [3:0]        div_code;
  logic [DATA_W-1:0] tx_byte, rx_byte;

  spi_bm_regs #(.NUM_SEL(NUM_SEL)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .re(bus_re), .rdata(bus_rdata), .busy(busy),
    .done_pulse(done_pulse), .rx_byte(rx_byte), .en(en), .cpol(cpol),
    .cpha(cpha), .div_code(div_code), .start(start), .tx_byte(tx_byte),
    .sel_n(sel_n)
  );

  spi_bm_clkdiv #(.EXP_MAX(spi_bm_pkg::DIV_EXP_MAX)) div_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .code(div_code), .tick(tick)
  );

  spi_bm_engine #(.DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .cpha(cpha),
    .tx_in(tx_byte), .miso(miso), .busy(busy), .sck_int(sck_int),
    .mosi(mosi), .rx_byte(rx_byte), .done_pulse(done_pulse)
  );

  assign sck = cpol ^ sck_int;

  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));

  assert_no_start_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy) |=> !busy);

endmodule

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       bus_we, bus_re;
  logic       sck, mosi, miso;
  logic [3:0] sel_n;

  int n_chk = 0, n_bad = 0;

  spi_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .sel_n(sel_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  // slave model and scoreboard monitor
  logic [7:0] exp_q[$];
  logic       s_act = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0;
  logic [7:0] s_tx, s_rx;
  int         s_cnt;

  always @(sck) begin
    if (s_act && rst_n) begin
      if (((sck != s_cpol) ^ s_cpha) == 1'b1) begin
        s_rx = {s_rx[6:0], mosi};
        s_cnt++;
        if (s_cnt == 8) begin
          if (exp_q.size() == 0) chk("R4 slave got unexpected byte", 32'(s_rx), 32'hxx);
          else chk("R4/R5 slave received MOSI byte", 32'(s_rx), 32'(exp_q.pop_front()));
        end
      end else if (s_cpha) begin
        miso = s_tx[7];
        s_tx = {s_tx[6:0], 1'b0};
      end else begin
        s_tx = {s_tx[6:0], 1'b0};
        miso = s_tx[7];
      end
    end
  end

  // SCK period measurement (rising to rising)
  int   rise_n = 0;
  time  t_r0, t_r1;
  always @(posedge sck) begin
    if (rise_n == 0) t_r0 = $time;
    else if (rise_n == 1) t_r1 = $time;
    rise_n++;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    do rd(3'h1, s); while (s[7] !== 1'b1);
  endtask

  task automatic setup_xfer(input logic p, input logic h, input logic [3:0] code,
                            input logic [7:0] txb, input logic [7:0] slb);
    wr(3'h0, 8'h40 | {4'b0, p, h, code[1:0]});
    wr(3'h3, {6'b0, code[3:2]});
    s_cpol = p; s_cpha = h; s_tx = slb; s_rx = '0; s_cnt = 0;
    miso = slb[7];
    exp_q.push_back(txb);
    rise_n = 0;
    s_act = 1'b1;
  endtask

  task automatic xfer(input logic p, input logic h, input logic [3:0] code,
                      input logic [7:0] txb, input logic [7:0] slb, input string tag);
    logic [7:0] v;
    setup_xfer(p, h, code, txb, slb);
    wr(3'h2, txb);
    wait_done();
    s_act = 1'b0;
    rd(3'h1, v);
    chk({tag, " R6/R7 status after exchange"}, 32'(v), 32'h80);
    rd(3'h2, v);
    chk({tag, " R4 captured byte"}, 32'(v), 32'(slb));
    rd(3'h1, v);
    chk({tag, " R7 empty after data read"}, 32'(v), 32'h81);
    wr(3'h1, 8'h40);
    rd(3'h1, v);
    chk({tag, " R6 write 0 to bit7 keeps flag"}, 32'(v), 32'h81);
    wr(3'h1, 8'hC0);
    rd(3'h1, v);
    chk({tag, " R6 W1C clears"}, 32'(v), 32'h01);
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0; miso = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(3'h0, v); chk("R1 control reset", 32'(v), 32'h00);
    rd(3'h1, v); chk("R1 status reset", 32'(v), 32'h01);
    chk("R1 selects high", 32'(sel_n), 32'hF);
    chk("R1 sck low", 32'(sck), 32'h0);

    // R2 readback
    wr(3'h3, 8'hA6); rd(3'h3, v); chk("R2 extended readback", 32'(v), 32'hA6);
    wr(3'h6, 8'h5A); rd(3'h6, v); chk("R2 timing readback", 32'(v), 32'h5A);
    wr(3'h4, 8'h3D); rd(3'h4, v); chk("R2 parameter readback", 32'(v), 32'h3D);
    wr(3'h0, 8'hB7); rd(3'h0, v); chk("R2 control readback", 32'(v), 32'hB7);

    // R10 selects
    wr(3'h5, 8'h5F); rd(3'h5, v); chk("R2 select readback", 32'(v), 32'h5F);
    #1 chk("R10 all enabled, levels 0101", 32'(sel_n), 32'h5);
    wr(3'h5, 8'h23);
    #1 chk("R10 two enabled, others high", 32'(sel_n), 32'hE);
    wr(3'h5, 8'hF0);
    #1 chk("R10 levels ignored when disabled", 32'(sel_n), 32'hF);

    // R9 disabled controller
    wr(3'h0, 8'h08);
    #1 chk("R9 idle sck follows polarity", 32'(sck), 32'h1);
    wr(3'h2, 8'h55);
    repeat (40) @(posedge clk);
    #1 chk("R9 sck stays idle", 32'(sck), 32'h1);
    rd(3'h1, v); chk("R9 no exchange started", 32'(v), 32'h01);

    // R4/R5 all modes, fastest ratio (R11: parameter bit0 = 0)
    wr(3'h4, 8'h00);
    xfer(1'b0, 1'b0, 4'd0, 8'hA5, 8'h3C, "mode0 R11");
    xfer(1'b0, 1'b1, 4'd0, 8'h96, 8'hC3, "mode1 R5");
    xfer(1'b1, 1'b0, 4'd0, 8'h01, 8'h80, "mode2 R5");
    xfer(1'b1, 1'b1, 4'd0, 8'hFE, 8'h7F, "mode3 R5");
    wr(3'h4, 8'h01);
    xfer(1'b0, 1'b0, 4'd1, 8'h5C, 8'hE1, "param1 R11");

    // R3 divider codes (mode 0: rising to rising is one period)
    begin
      logic [3:0] codes [9] = '{4'd0, 4'd1, 4'd4, 4'd2, 4'd3, 4'd5, 4'd6, 4'd11, 4'd15};
      int         ratio [9] = '{2, 4, 8, 16, 32, 64, 128, 4096, 4096};
      for (int k = 0; k < 9; k++) begin
        xfer(1'b0, 1'b0, codes[k], 8'(k * 37 + 3), 8'(k * 91 + 5), "div R3");
        chk($sformatf("R3 period code %0d", codes[k]),
            32'((t_r1 - t_r0) / CLK_PERIOD), 32'(ratio[k]));
      end
    end

    // R8 collision
    setup_xfer(1'b0, 1'b0, 4'd3, 8'hC9, 8'h6B);
    wr(3'h2, 8'hC9);
    repeat (40) @(posedge clk);
    wr(3'h2, 8'h12);
    rd(3'h1, v); chk("R8 collision flag set", 32'(v[6]), 32'h1);
    wait_done();
    s_act = 1'b0;
    rd(3'h2, v); chk("R8 captured byte unchanged", 32'(v), 32'h6B);
    wr(3'h1, 8'h40);
    rd(3'h1, v); chk("R8 collision cleared by W1C", 32'(v), 32'h81);
    wr(3'h1, 8'h80);

    repeat (20) @(posedge clk);
    chk("R4 all expected MOSI bytes seen", 32'(exp_q.size()), 32'h0);
    finish_run();
  end

endmodule